// File: doc/BRIEF.md
# Programmable Clock Generator Divider

This block derives one clock from a single source clock. A control word decides whether the generator runs and how the source is divided. There are two divide laws. In the linear law the factor is the divide value, and a value of 0 or 1 passes the source through. In the power-of-two law the factor is two raised to the divide value plus one, and the exponent is capped at 8. For odd linear factors an optional correction stage, clocked on the falling source edge, adds half a source cycle to the high phase so that the high and low times are equal.

The generated clock also drives an output pin. The pin carries the clock only when the pin output is enabled, the generator is running and the pin is not itself the chosen source. Otherwise the pin holds a programmable idle level. Two inputs decide whether the generator runs: a standby indication and a peripheral clock request. With the pin output enabled, the generator runs outside standby, and it runs in standby only if run-in-standby is set. With the pin output disabled, it runs only while a peripheral requests its clock.

A new control word, and every start or stop, takes effect only at the end of the current output period, so the output never carries a shortened pulse. A change of output enable reaches the pin at the next falling source edge.

Top module: `clk_gen_div`

## Requirements
- R1: With `cfg_enable` at 0 the generator stops at the end of its current period, and `gen_clk_o` then stays at 0.
- R2: With `cfg_pow2` at 0 the output period is `cfg_div` source cycles, and a `cfg_div` of 0 or 1 gives the source clock unchanged, with a period of one source cycle and a high time of half a cycle.
- R3: With `cfg_pow2` at 1 the output period is 2^(e+1) source cycles, where e is `cfg_div` limited to at most 8.
- R4: With `cfg_duty_fix` at 0, an odd factor N greater than 1 gives a high time of floor(N/2) source cycles. An even factor gives exactly N/2 in either duty mode.
- R5: With `cfg_duty_fix` at 1, an odd factor N greater than 1 gives a high time of N/2 source cycles, in half-cycle resolution.
- R6: While the generator runs with `cfg_pin_oe` at 1 and `cfg_src_is_pin` at 0, `pin_o` follows `gen_clk_o`. When the generator is stopped or `cfg_pin_oe` is 0, `pin_o` equals `cfg_pin_idle`.
- R7: With `cfg_src_is_pin` at 1, `pin_drive_o` is 0 and `pin_o` equals `cfg_pin_idle`, even when `cfg_pin_oe` is 1.
- R8: With the pin output in effect and `standby_i` at 1, the generator keeps running if `cfg_stby_run` is 1. If `cfg_stby_run` is 0 it stops and `pin_o` equals `cfg_pin_idle`.
- R9: With the pin output not in effect, the generator runs only while `periph_req_i` is 1, and `cfg_stby_run` has no effect.
- R10: A change of divide settings takes effect only at a period boundary, so every high and every low phase has the length given by either the old settings or the new ones.
- R11: The internal period counter always stays below the active factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Selected source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Generator enable |
| cfg_pow2 | input | 1 | Divide law: 0 linear, 1 power of two |
| cfg_div | input | DIV_W | Divide value or exponent |
| cfg_duty_fix | input | 1 | Equal high/low time for odd linear factors |
| cfg_pin_oe | input | 1 | Put the generated clock on the pin |
| cfg_pin_idle | input | 1 | Pin level while the clock is not on the pin |
| cfg_stby_run | input | 1 | Keep running in standby while the pin output is in effect |
| cfg_src_is_pin | input | 1 | The pin is the source, so it is not driven |
| standby_i | input | 1 | Standby indication |
| periph_req_i | input | 1 | Peripheral requests the generated clock |
| gen_clk_o | output | 1 | Generated clock |
| pin_o | output | 1 | Pin value |
| pin_drive_o | output | 1 | Pin output-driver enable |

## Verification
The assertions assume that every control, standby and request input is synchronous to `src_clk` and stable around its rising edge. They also assume that the reset is held low for at least one full source cycle, so that the falling-edge stages are cleared as well. The stimulus changes inputs only a quarter period after a source edge. It samples the outputs once in every half cycle, which lets the bench see the half-cycle extension added by the duty correction. A sweep over divide values stays within that input discipline because it changes the configuration while the generator runs, which is the case that the period-boundary property covers.

// File: rtl/clk_gen_div_pkg.sv
// Shared types for the clock generator divider.
package clk_gen_div_pkg;
    // Run state of the period sequencer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/clk_gen_div_factor.sv
// Decodes the divide settings into a factor N, the high-phase length and the
// odd-factor correction flag.
// Assumes: combinational only; the power-of-two exponent is capped so that N
// fits into DIV_W+2 bits.
module clk_gen_div_factor #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             pow2_sel,
    input  logic             duty_fix,
    output logic [DIV_W+1:0] factor,
    output logic [DIV_W+1:0] high_cnt,
    output logic             odd_fix
);
    localparam int CNT_W   = DIV_W + 1;
    localparam int N_W     = DIV_W + 2;
    localparam int EXP_MAX = CNT_W - 1;

    logic [DIV_W-1:0] exp_c;

    // Choose the factor for the selected divide law.
    always_comb begin
        exp_c = (div_val > DIV_W'(EXP_MAX)) ? DIV_W'(EXP_MAX) : div_val;
        if (pow2_sel) begin
            factor = N_W'(1) << (exp_c + DIV_W'(1));
        end else if (div_val < DIV_W'(2)) begin
            factor = N_W'(1);
        end else begin
            factor = N_W'(div_val);
        end
    end

    // The high phase is floor(N/2) source cycles; correction applies to odd N above 1.
    always_comb begin
        high_cnt = factor >> 1;
        odd_fix  = duty_fix && factor[0] && (factor != N_W'(1));
    end
endmodule

// File: rtl/clk_gen_div_seq.sv
// Period sequencer on the rising source edge. It counts source cycles within
// an output period, holds the active settings, and registers the high phase.
// Assumes: run_req and the decoded settings are synchronous to clk. Settings,
// starts and stops are accepted only at a period boundary.
module clk_gen_div_seq
    import clk_gen_div_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [DIV_W+1:0] factor,
    input  logic [DIV_W+1:0] high_cnt,
    input  logic             odd_fix,
    input  logic             oe_eff,
    output logic             running,
    output logic             period_end,
    output logic [DIV_W:0]   cnt,
    output logic [DIV_W+1:0] n_act,
    output logic [DIV_W+1:0] h_act,
    output logic             fix_act,
    output logic             oe_act,
    output logic             pos_q
);
    localparam int CNT_W = DIV_W + 1;
    localparam int N_W   = DIV_W + 2;

    run_state_e       state;
    logic [N_W-1:0]   cnt_ext;

    // Flag the last source cycle of the active period.
    always_comb begin
        cnt_ext    = {1'b0, cnt};
        running    = (state == ST_RUN);
        period_end = running && (cnt_ext == (n_act - N_W'(1)));
    end

    // Advance the count, and reload settings or stop at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            n_act   <= N_W'(1);
            h_act   <= '0;
            fix_act <= 1'b0;
            oe_act  <= 1'b0;
            pos_q   <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (run_req) begin
                state   <= ST_RUN;
                n_act   <= factor;
                h_act   <= high_cnt;
                fix_act <= odd_fix;
                oe_act  <= oe_eff;
                cnt     <= CNT_W'(factor - N_W'(1));
                pos_q   <= 1'b0;
            end
        end else if (period_end) begin
            cnt <= '0;
            if (run_req) begin
                n_act   <= factor;
                h_act   <= high_cnt;
                fix_act <= odd_fix;
                oe_act  <= oe_eff;
                pos_q   <= (high_cnt != '0);
            end else begin
                state <= ST_IDLE;
                pos_q <= 1'b0;
            end
        end else begin
            cnt   <= cnt + CNT_W'(1);
            pos_q <= ((cnt_ext + N_W'(1)) < h_act);
        end
    end
endmodule

// File: rtl/clk_gen_div_out.sv
// Output stage: the falling-edge half-cycle extension, the glitch-free
// pass-through gate for a factor of 1, and the pin multiplexer.
// Assumes: running, fix_act, oe_act and pos_q change only just after a rising
// edge, so sampling them on the falling edge is free of glitches.
module clk_gen_div_out (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic n_is_one,
    input  logic fix_act,
    input  logic oe_act,
    input  logic pos_q,
    input  logic idle_val,
    output logic gen_clk,
    output logic pin_val
);
    logic neg_q;
    logic byp_q;
    logic sel_q;

    // Falling-edge stage: half-cycle extension, bypass gate and pin select.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            byp_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            neg_q <= pos_q && fix_act;
            byp_q <= running && n_is_one;
            sel_q <= running && oe_act;
        end
    end

    // Combine the phases into the clock and choose the pin value.
    always_comb begin
        gen_clk = pos_q || neg_q || (clk && byp_q);
        pin_val = sel_q ? gen_clk : idle_val;
    end
endmodule

// File: rtl/clk_gen_div.sv
// Top level of the programmable clock generator divider. It decides when the
// generator should run, decodes the divide settings and connects the
// sequencer to the output stage.
// Assumes: all inputs are synchronous to src_clk; the reset is synchronous,
// active low, and held for at least one full source cycle.
module clk_gen_div #(
    parameter int DIV_W = 8
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_pow2,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_duty_fix,
    input  logic             cfg_pin_oe,
    input  logic             cfg_pin_idle,
    input  logic             cfg_stby_run,
    input  logic             cfg_src_is_pin,
    input  logic             standby_i,
    input  logic             periph_req_i,
    output logic             gen_clk_o,
    output logic             pin_o,
    output logic             pin_drive_o
);
    localparam int N_W = DIV_W + 2;

    logic             oe_eff;
    logic             run_req;
    logic [N_W-1:0]   factor;
    logic [N_W-1:0]   high_cnt;
    logic             odd_fix;
    logic             running;
    logic             period_end;
    logic [DIV_W:0]   cnt;
    logic [N_W-1:0]   n_act;
    logic [N_W-1:0]   h_act;
    logic             fix_act;
    logic             oe_act;
    logic             pos_q;

    // Decide whether the generator is wanted under the current conditions.
    always_comb begin
        oe_eff      = cfg_pin_oe && !cfg_src_is_pin;
        run_req     = cfg_enable && (oe_eff ? (!standby_i || cfg_stby_run) : periph_req_i);
        pin_drive_o = !cfg_src_is_pin;
    end

    clk_gen_div_factor #(.DIV_W(DIV_W)) u_factor (
        .div_val  (cfg_div),
        .pow2_sel (cfg_pow2),
        .duty_fix (cfg_duty_fix),
        .factor   (factor),
        .high_cnt (high_cnt),
        .odd_fix  (odd_fix)
    );

    clk_gen_div_seq #(.DIV_W(DIV_W)) u_seq (
        .clk        (src_clk),
        .rst_n      (rst_n),
        .run_req    (run_req),
        .factor     (factor),
        .high_cnt   (high_cnt),
        .odd_fix    (odd_fix),
        .oe_eff     (oe_eff),
        .running    (running),
        .period_end (period_end),
        .cnt        (cnt),
        .n_act      (n_act),
        .h_act      (h_act),
        .fix_act    (fix_act),
        .oe_act     (oe_act),
        .pos_q      (pos_q)
    );

    clk_gen_div_out u_out (
        .clk      (src_clk),
        .rst_n    (rst_n),
        .running  (running),
        .n_is_one (n_act == N_W'(1)),
        .fix_act  (fix_act),
        .oe_act   (oe_act),
        .pos_q    (pos_q),
        .idle_val (cfg_pin_idle),
        .gen_clk  (gen_clk_o),
        .pin_val  (pin_o)
    );
endmodule

// File: rtl/clk_gen_div_chk.sv
// Property checker for clk_gen_div, attached to every instance by bind.
module clk_gen_div_chk #(
    parameter int DIV_W = 8
) (
    input logic             src_clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_pin_oe,
    input logic             cfg_pin_idle,
    input logic             cfg_stby_run,
    input logic             cfg_src_is_pin,
    input logic             standby_i,
    input logic             periph_req_i,
    input logic             pin_o,
    input logic             running,
    input logic             period_end,
    input logic [DIV_W:0]   cnt,
    input logic [DIV_W+1:0] n_act,
    input logic [DIV_W+1:0] h_act,
    input logic             pos_q
);
    // R11: the counter stays below the active factor.
    p_no_overflow_r11: assert property (@(posedge src_clk) disable iff (!rst_n)
        running |-> ({1'b0, cnt} < n_act));

    // R10: the active settings hold inside a period.
    p_cfg_hold_r10: assert property (@(posedge src_clk) disable iff (!rst_n)
        (running && $past(running) && (cnt != '0)) |-> ($stable(n_act) && $stable(h_act)));

    // R1: a disabled idle generator does not start.
    p_disabled_idle_r1: assert property (@(posedge src_clk) disable iff (!rst_n)
        (!running && !cfg_enable) |=> !running);

    // R4: the output is low in the last cycle of a divided period.
    p_low_at_end_r4: assert property (@(posedge src_clk) disable iff (!rst_n)
        (period_end && (n_act > 1)) |-> !pos_q);

    // R8: standby without run-in-standby stops the generator at the boundary.
    p_standby_stop_r8: assert property (@(posedge src_clk) disable iff (!rst_n)
        (period_end && cfg_pin_oe && !cfg_src_is_pin && standby_i && !cfg_stby_run) |=> !running);

    // R9: with the pin output off, no request means no start.
    p_no_request_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
        (!running && !(cfg_pin_oe && !cfg_src_is_pin) && !periph_req_i) |=> !running);

    // R6: a stopped generator leaves the pin at its idle level.
    p_idle_pin_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
        !running |-> (pin_o == cfg_pin_idle));
endmodule

bind clk_gen_div clk_gen_div_chk #(.DIV_W(DIV_W)) u_chk (
    .src_clk        (src_clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_pin_oe     (cfg_pin_oe),
    .cfg_pin_idle   (cfg_pin_idle),
    .cfg_stby_run   (cfg_stby_run),
    .cfg_src_is_pin (cfg_src_is_pin),
    .standby_i      (standby_i),
    .periph_req_i   (periph_req_i),
    .pin_o          (pin_o),
    .running        (running),
    .period_end     (period_end),
    .cnt            (cnt),
    .n_act          (n_act),
    .h_act          (h_act),
    .pos_q          (pos_q)
);

// File: tb/clk_gen_div_bench.sv
// Self-checking bench: samples the outputs once per source half cycle and
// compares the period and high time with values computed arithmetically.
module clk_gen_div_bench;
    localparam int CLK_P = 10;
    localparam int DIV_W = 8;

    logic             src_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_enable = 1'b0;
    logic             cfg_pow2 = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             cfg_duty_fix = 1'b0;
    logic             cfg_pin_oe = 1'b0;
    logic             cfg_pin_idle = 1'b0;
    logic             cfg_stby_run = 1'b0;
    logic             cfg_src_is_pin = 1'b0;
    logic             standby_i = 1'b0;
    logic             periph_req_i = 1'b0;
    logic             gen_clk_o;
    logic             pin_o;
    logic             pin_drive_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    clk_gen_div #(.DIV_W(DIV_W)) u_clk_gen_div (.*);

    always #(CLK_P/2) src_clk = ~src_clk;

    // Record one check; on a mismatch print the requirement and both values.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample the outputs a quarter period after the next source edge.
    task automatic get_half(output logic g, output logic p);
        @(src_clk);
        #(CLK_P/4);
        g = gen_clk_o;
        p = pin_o;
    endtask

    task automatic skip_halves(input int n);
        logic g, p;
        for (int i = 0; i < n; i++) get_half(g, p);
    endtask

    // Measure one output period in half cycles, from one rising edge to the next.
    task automatic measure(output int per_h, output int hi_h);
        logic v, prev, p;
        bit found = 1'b0;
        per_h = -1;
        hi_h = -1;
        get_half(prev, p);
        for (int i = 0; i < 4000 && !found; i++) begin
            get_half(v, p);
            if (v && !prev) found = 1'b1;
            prev = v;
        end
        if (found) begin
            per_h = 1;
            hi_h = 1;
            found = 1'b0;
            for (int i = 0; i < 4000 && !found; i++) begin
                get_half(v, p);
                if (v && !prev) found = 1'b1;
                else begin
                    per_h++;
                    if (v) hi_h++;
                end
                prev = v;
            end
            if (!found) per_h = -1;
        end
    endtask

    // Count toggles on both outputs and pin-versus-clock mismatches.
    task automatic observe(input int n, output int g_edges, output int p_edges,
                           output int mism, output logic g_last, output logic p_last);
        logic g, p, gp, pp;
        g_edges = 0;
        p_edges = 0;
        mism = 0;
        get_half(gp, pp);
        for (int i = 0; i < n; i++) begin
            get_half(g, p);
            if (g != gp) g_edges++;
            if (p != pp) p_edges++;
            if (p != g) mism++;
            gp = g;
            pp = p;
        end
        g_last = gp;
        p_last = pp;
    endtask

    function automatic int exp_factor(input bit p2, input int d);
        if (p2) return 1 << (((d > 8) ? 8 : d) + 1);
        return (d < 2) ? 1 : d;
    endfunction

    function automatic int exp_high(input int n, input bit fix);
        if (n == 1) return 1;
        if (n % 2 == 0) return n;
        return fix ? n : n - 1;
    endfunction

    // Apply one divide setting and check the second full period after it.
    task automatic sweep_one(input bit p2, input int d, input bit fix);
        int per_h, hi_h, n;
        cfg_pow2 = p2;
        cfg_div = DIV_W'(d);
        cfg_duty_fix = fix;
        n = exp_factor(p2, d);
        measure(per_h, hi_h);
        measure(per_h, hi_h);
        if (p2) check(per_h == 2 * n, "R3 period", per_h, 2 * n);
        else    check(per_h == 2 * n, "R2 period", per_h, 2 * n);
        if (fix) check(hi_h == exp_high(n, fix), "R5 high time", hi_h, exp_high(n, fix));
        else     check(hi_h == exp_high(n, fix), "R4 high time", hi_h, exp_high(n, fix));
    endtask

    initial begin
        int ge, pe, mm;
        logic gl, pl;
        cfg_pin_idle = 1'b1;
        repeat (4) @(posedge src_clk);
        #(CLK_P/4);
        rst_n = 1'b1;
        skip_halves(2);
        // Reset state: clock low, pin at its idle level.
        check(gen_clk_o == 1'b0, "R1 reset clock", gen_clk_o, 0);
        check(pin_o == 1'b1, "R6 reset pin", pin_o, 1);

        // Divide sweeps with the generator running on a peripheral request.
        cfg_enable = 1'b1;
        periph_req_i = 1'b1;
        for (int d = 0; d < 14; d++) begin
            sweep_one(1'b0, d, 1'b0);
            sweep_one(1'b0, d, 1'b1);
        end
        sweep_one(1'b0, 255, 1'b1);
        sweep_one(1'b0, 255, 1'b0);
        for (int d = 0; d < 11; d++) sweep_one(1'b1, d, 1'b0);
        sweep_one(1'b1, 3, 1'b1);

        // R10: switch from factor 7 to factor 3 in mid-period; phases stay whole.
        begin
            logic g, p, prev;
            int run, bad;
            bit started;
            cfg_pow2 = 1'b0;
            cfg_duty_fix = 1'b0;
            cfg_div = 8'd7;
            skip_halves(40);
            get_half(prev, p);
            run = 0;
            bad = 0;
            started = 1'b0;
            for (int i = 0; i < 100; i++) begin
                get_half(g, p);
                if (i == 37) cfg_div = 8'd3;
                if (g != prev) begin
                    if (started) begin
                        if (prev && run != 6 && run != 2) bad++;
                        if (!prev && run != 8 && run != 4) bad++;
                    end
                    started = 1'b1;
                    run = 1;
                end else run++;
                prev = g;
            end
            check(bad == 0, "R10 whole phases", bad, 0);
        end

        // R6: pin follows the clock with the output enabled.
        cfg_div = 8'd4;
        cfg_pin_oe = 1'b1;
        cfg_pin_idle = 1'b0;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(mm == 0, "R6 pin follows clock", mm, 0);
        check(pe > 0, "R6 pin toggles", pe, 1);
        check(pin_drive_o == 1'b1, "R7 driver on", pin_drive_o, 1);

        // R6: output disabled, pin held at the idle level while the clock runs.
        cfg_pin_oe = 1'b0;
        cfg_pin_idle = 1'b1;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(pe == 0 && pl == 1'b1, "R6 pin idle high", pl, 1);
        check(ge > 0, "R9 runs on request", ge, 1);
        cfg_pin_idle = 1'b0;
        skip_halves(4);
        observe(20, ge, pe, mm, gl, pl);
        check(pe == 0 && pl == 1'b0, "R6 pin idle low", pl, 0);

        // R7: the pin is the source, so it is not driven even with the output enabled.
        cfg_pin_oe = 1'b1;
        cfg_src_is_pin = 1'b1;
        cfg_pin_idle = 1'b1;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(pin_drive_o == 1'b0, "R7 driver off", pin_drive_o, 0);
        check(pe == 0 && pl == 1'b1, "R7 pin idle", pl, 1);
        cfg_src_is_pin = 1'b0;

        // R8: standby with and without run-in-standby, no request.
        periph_req_i = 1'b0;
        standby_i = 1'b1;
        cfg_stby_run = 1'b1;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(ge > 0 && mm == 0, "R8 runs in standby", ge, 1);
        cfg_stby_run = 1'b0;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(ge == 0 && gl == 1'b0, "R8 stops in standby", ge, 0);
        check(pe == 0 && pl == 1'b1, "R8 pin idle in standby", pl, 1);

        // R9: output disabled; run-in-standby has no effect without a request.
        cfg_pin_oe = 1'b0;
        cfg_stby_run = 1'b1;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(ge == 0, "R9 stby_run ignored", ge, 0);
        standby_i = 1'b0;
        skip_halves(4);
        observe(40, ge, pe, mm, gl, pl);
        check(ge == 0, "R9 no request", ge, 0);
        periph_req_i = 1'b1;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(ge > 0, "R9 request starts", ge, 1);

        // R1: disable stops the clock.
        cfg_enable = 1'b0;
        skip_halves(20);
        observe(40, ge, pe, mm, gl, pl);
        check(ge == 0 && gl == 1'b0, "R1 disabled", ge, 0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge src_clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule